// File: doc/BRIEF.md
# Dual-Rail Ripple ALU with Completion-Gated Output

This block is an N-bit arithmetic and logic unit in which every operand bit, every control bit and every result bit is carried on a pair of wires. The pair {true rail, false rail} reads 10 for a logic one and 01 for a logic zero. It reads 00 for the null spacer, and 11 is never legal. The block is driven in alternating waves. A data wave puts valid data on every input pair and waits for the result. A null wave returns every input pair to 00 and waits for the outputs to return to null. Nothing in the block assumes that inputs arrive together.

Inside, every gate is a threshold gate with hysteresis, modelled as a clocked state-holding element. A gate sets once enough of its weighted inputs are high. It clears only when all of its inputs are low, and otherwise it keeps its value. Operand B passes through a selector that can swap its rails, which inverts it for free. A ripple chain of dual-rail full adders then adds it to operand A, with the subtract control pair used directly as the carry-in. A bitwise unit forms AND or OR. An output selector chooses the arithmetic or the logic result. A final registered stage lets the result and carry-out change only as a whole, once every input and every internal result bit agree.

Top module: `nclv_alu`

## Requirements
- R1: Every rail pair at the ports uses {t,f} = 10 for one, 01 for zero, 00 for null, and 11 is illegal; the outputs never show 11.
- R2: The result and carry-out pairs are at all times either all null or all data; they never show a mix.
- R3: While any input pair (operand bit or control) is still null, the outputs stay null, even when all other inputs are data.
- R4: Once the outputs hold data, they keep the same value until every input pair is null; they then return to all null.
- R5: With sub = 0 and rsel = 0 (arithmetic), the result is (A + B) mod 2^N and ovf is the carry out of bit N-1.
- R6: With sub = 1 and rsel = 0, the result is (A + ~B + 1) mod 2^N, which is A - B in two's complement, and ovf is the carry out of bit N-1 (1 when A >= B unsigned).
- R7: With rsel = 1 and lop = 0, the result is the bitwise AND of A and B.
- R8: With rsel = 1 and lop = 1, the result is the bitwise OR of A and B.
- R9: ovf always reports the adder carry of A + (sub ? ~B : B) + sub, in logic mode as well.
- R10: rail_err rises one clock after any input pair shows 11 and stays high until reset.
- R11: A synchronous active-high reset makes every output pair null and clears rail_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the state-holding gates |
| rst | input | 1 | Synchronous active-high reset |
| opa_t | input | WIDTH | Operand A true rails |
| opa_f | input | WIDTH | Operand A false rails |
| opb_t | input | WIDTH | Operand B true rails |
| opb_f | input | WIDTH | Operand B false rails |
| sub_t | input | 1 | Subtract select, true rail |
| sub_f | input | 1 | Subtract select, false rail |
| lop_t | input | 1 | Logic op select (one = OR, zero = AND), true rail |
| lop_f | input | 1 | Logic op select, false rail |
| rsel_t | input | 1 | Result select (one = logic, zero = arithmetic), true rail |
| rsel_f | input | 1 | Result select, false rail |
| res_t | output | WIDTH | Result true rails |
| res_f | output | WIDTH | Result false rails |
| ovf_t | output | 1 | Adder carry-out, true rail |
| ovf_f | output | 1 | Adder carry-out, false rail |
| rail_err | output | 1 | Sticky flag for an illegal 11 input pair |

## Verification
A threshold gate that fails to hold its state or to clear shows up in one of three ways. It can make the outputs leave null before the last late input bit arrives, which is visible in the cycle after the skew is resolved. It can make the outputs drop or change during a half-null wave. Or it can leave a stale value in the next data wave, which gives a wrong result or carry at the first output transition. A broken carry link changes the sum only in the bits above it, so carries are driven across the full width, including wrap-around and equal-operand subtraction. A fault in the completion stage shows up as a mixed null/data output in any single cycle.

// File: rtl/nclv_pkg.sv
package nclv_pkg;
  // one dual-rail pair: [1] = true rail, [0] = false rail
  typedef logic [1:0] rail_t;
endpackage

// File: rtl/nclv_thgate.sv
module nclv_thgate #(
  parameter int NIN = 2,
  parameter int THR = 2,
  parameter int W0  = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NIN-1:0] din,
  output logic           dout
);
  localparam int SW = $clog2(NIN + W0 + 1) + 1;

  logic [SW-1:0] wsum;

  // weighted count of asserted inputs; input 0 carries weight W0
  always_comb begin
    wsum = '0;
    for (int i = 0; i < NIN; i++) begin
      if (din[i]) wsum = wsum + ((i == 0) ? SW'(W0) : SW'(1));
    end
  end

  // hysteresis: set at threshold, clear only when every input is low
  always_ff @(posedge clk) begin
    if (rst)                   dout <= 1'b0;
    else if (wsum >= SW'(THR)) dout <= 1'b1;
    else if (wsum == '0)       dout <= 1'b0;
  end
endmodule

// File: rtl/nclv_mux.sv
module nclv_mux
  import nclv_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  rail_t sel,
  input  rail_t x,
  input  rail_t y,
  output rail_t q
);
  for (genvar r = 0; r < 2; r++) begin : g_rail
    logic tx, ty;
    nclv_thgate #(.NIN(2), .THR(2), .W0(1)) u_tx (
      .clk(clk), .rst(rst), .din({x[r], sel[0]}), .dout(tx));
    nclv_thgate #(.NIN(2), .THR(2), .W0(1)) u_ty (
      .clk(clk), .rst(rst), .din({y[r], sel[1]}), .dout(ty));
    nclv_thgate #(.NIN(2), .THR(1), .W0(1)) u_or (
      .clk(clk), .rst(rst), .din({ty, tx}), .dout(q[r]));
  end
endmodule

// File: rtl/nclv_fa.sv
module nclv_fa
  import nclv_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  rail_t a,
  input  rail_t b,
  input  rail_t ci,
  output rail_t s,
  output rail_t co
);
  // carry rails: 2-of-3 with hysteresis on each rail
  nclv_thgate #(.NIN(3), .THR(2), .W0(1)) u_co1 (
    .clk(clk), .rst(rst), .din({ci[1], b[1], a[1]}), .dout(co[1]));
  nclv_thgate #(.NIN(3), .THR(2), .W0(1)) u_co0 (
    .clk(clk), .rst(rst), .din({ci[0], b[0], a[0]}), .dout(co[0]));
  // sum rails: 3-of-4 with the opposite carry rail weighted 2
  nclv_thgate #(.NIN(4), .THR(3), .W0(2)) u_s1 (
    .clk(clk), .rst(rst), .din({ci[1], b[1], a[1], co[0]}), .dout(s[1]));
  nclv_thgate #(.NIN(4), .THR(3), .W0(2)) u_s0 (
    .clk(clk), .rst(rst), .din({ci[0], b[0], a[0], co[1]}), .dout(s[0]));
endmodule

// File: rtl/nclv_out_stage.sv
module nclv_out_stage #(
  parameter int IW = 8,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] in_t,
  input  logic [IW-1:0] in_f,
  input  logic [RW-1:0] r_t,
  input  logic [RW-1:0] r_f,
  output logic [RW-1:0] q_t,
  output logic [RW-1:0] q_f,
  output logic          err
);
  logic in_data, in_null, r_data, r_null, in_bad;

  assign in_data = &(in_t ^ in_f);
  assign in_null = ~|(in_t | in_f);
  assign r_data  = &(r_t ^ r_f);
  assign r_null  = ~|(r_t | r_f);
  assign in_bad  = |(in_t & in_f);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_t <= '0;
      q_f <= '0;
    end else if (in_data && r_data) begin
      q_t <= r_t;
      q_f <= r_f;
    end else if (in_null && r_null) begin
      q_t <= '0;
      q_f <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= err | in_bad;
  end
endmodule

// File: rtl/nclv_alu.sv
module nclv_alu
  import nclv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opa_t,
  input  logic [WIDTH-1:0] opa_f,
  input  logic [WIDTH-1:0] opb_t,
  input  logic [WIDTH-1:0] opb_f,
  input  logic             sub_t,
  input  logic             sub_f,
  input  logic             lop_t,
  input  logic             lop_f,
  input  logic             rsel_t,
  input  logic             rsel_f,
  output logic [WIDTH-1:0] res_t,
  output logic [WIDTH-1:0] res_f,
  output logic             ovf_t,
  output logic             ovf_f,
  output logic             rail_err
);
  localparam int IW = 2 * WIDTH + 3;
  localparam int RW = WIDTH + 1;

  rail_t sub_p, lop_p, rsel_p;
  rail_t car_p [WIDTH+1];
  logic [WIDTH-1:0] rt, rf;

  assign sub_p    = {sub_t, sub_f};
  assign lop_p    = {lop_t, lop_f};
  assign rsel_p   = {rsel_t, rsel_f};
  assign car_p[0] = sub_p;   // plus-one for subtraction

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    rail_t a_p, b_p, binv_p, bsel_p, sum_p, and_p, or_p, lg_p, res_p;
    logic  m00, m01, m10, m11;

    assign a_p    = {opa_t[i], opa_f[i]};
    assign b_p    = {opb_t[i], opb_f[i]};
    assign binv_p = {opb_f[i], opb_t[i]};   // inversion is a rail swap

    nclv_mux u_bsel (.clk(clk), .rst(rst), .sel(sub_p), .x(b_p), .y(binv_p), .q(bsel_p));

    nclv_fa u_fa (.clk(clk), .rst(rst), .a(a_p), .b(bsel_p), .ci(car_p[i]),
                  .s(sum_p), .co(car_p[i+1]));

    // minterms of the original operands
    nclv_thgate #(.NIN(2), .THR(2), .W0(1)) u_m00 (
      .clk(clk), .rst(rst), .din({b_p[0], a_p[0]}), .dout(m00));
    nclv_thgate #(.NIN(2), .THR(2), .W0(1)) u_m01 (
      .clk(clk), .rst(rst), .din({b_p[1], a_p[0]}), .dout(m01));
    nclv_thgate #(.NIN(2), .THR(2), .W0(1)) u_m10 (
      .clk(clk), .rst(rst), .din({b_p[0], a_p[1]}), .dout(m10));
    nclv_thgate #(.NIN(2), .THR(2), .W0(1)) u_m11 (
      .clk(clk), .rst(rst), .din({b_p[1], a_p[1]}), .dout(m11));

    assign and_p[1] = m11;
    nclv_thgate #(.NIN(3), .THR(1), .W0(1)) u_and0 (
      .clk(clk), .rst(rst), .din({m10, m01, m00}), .dout(and_p[0]));
    assign or_p[0] = m00;
    nclv_thgate #(.NIN(3), .THR(1), .W0(1)) u_or1 (
      .clk(clk), .rst(rst), .din({m10, m01, m11}), .dout(or_p[1]));

    nclv_mux u_lsel (.clk(clk), .rst(rst), .sel(lop_p), .x(and_p), .y(or_p), .q(lg_p));
    nclv_mux u_osel (.clk(clk), .rst(rst), .sel(rsel_p), .x(sum_p), .y(lg_p), .q(res_p));

    assign rt[i] = res_p[1];
    assign rf[i] = res_p[0];
  end

  logic [RW-1:0] q_t, q_f;

  nclv_out_stage #(.IW(IW), .RW(RW)) u_out (
    .clk (clk),
    .rst (rst),
    .in_t({opa_t, opb_t, sub_t, lop_t, rsel_t}),
    .in_f({opa_f, opb_f, sub_f, lop_f, rsel_f}),
    .r_t ({car_p[WIDTH][1], rt}),
    .r_f ({car_p[WIDTH][0], rf}),
    .q_t (q_t),
    .q_f (q_f),
    .err (rail_err)
  );

  assign res_t = q_t[WIDTH-1:0];
  assign res_f = q_f[WIDTH-1:0];
  assign ovf_t = q_t[WIDTH];
  assign ovf_f = q_f[WIDTH];
endmodule

// File: rtl/nclv_alu_chk.sv
module nclv_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] opa_t,
  input logic [WIDTH-1:0] opa_f,
  input logic [WIDTH-1:0] opb_t,
  input logic [WIDTH-1:0] opb_f,
  input logic             sub_t,
  input logic             sub_f,
  input logic             lop_t,
  input logic             lop_f,
  input logic             rsel_t,
  input logic             rsel_f,
  input logic [WIDTH-1:0] res_t,
  input logic [WIDTH-1:0] res_f,
  input logic             ovf_t,
  input logic             ovf_f,
  input logic             rail_err
);
  logic [2*WIDTH+2:0] it, iv;
  logic in_data, in_null, in_bad, out_data, out_null;

  assign it       = {opa_t, opb_t, sub_t, lop_t, rsel_t};
  assign iv       = {opa_f, opb_f, sub_f, lop_f, rsel_f};
  assign in_data  = &(it ^ iv);
  assign in_null  = ~|(it | iv);
  assign in_bad   = |(it & iv);
  assign out_data = &({ovf_t, res_t} ^ {ovf_f, res_f});
  assign out_null = ~|{ovf_t, res_t, ovf_f, res_f};

  assert_out_legal_R1: assert property (@(posedge clk) disable iff (rst)
    ((res_t & res_f) == '0) && !(ovf_t && ovf_f));

  assert_out_atomic_R2: assert property (@(posedge clk) disable iff (rst)
    out_null || out_data);

  assert_wait_inputs_R3: assert property (@(posedge clk) disable iff (rst)
    (out_null && !in_data) |=> out_null);

  assert_hold_data_R4: assert property (@(posedge clk) disable iff (rst)
    (out_data && !in_null) |=> (out_data && $stable(res_t) && $stable(res_f) && $stable(ovf_t)));

  assert_err_set_R10: assert property (@(posedge clk) disable iff (rst)
    in_bad |=> rail_err);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    rail_err |=> rail_err);
endmodule

bind nclv_alu nclv_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/nclv_alu_tb.sv
`timescale 1ns/1ps
module nclv_alu_tb;
  localparam int W    = 32;
  localparam int SKEW = 80;
  localparam int WAIT = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] opa_t = '0, opa_f = '0, opb_t = '0, opb_f = '0;
  logic sub_t = 1'b0, sub_f = 1'b0, lop_t = 1'b0, lop_f = 1'b0, rsel_t = 1'b0, rsel_f = 1'b0;
  logic [W-1:0] res_t, res_f;
  logic ovf_t, ovf_f, rail_err;

  always #2.5 clk = ~clk;

  nclv_alu #(.WIDTH(W)) u_dut (.*);

  typedef struct {
    logic [W-1:0] res;
    logic         ovf;
    string        req;
  } exp_t;
  exp_t sb_q[$];

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic out_data, out_null;
  assign out_data = &({ovf_t, res_t} ^ {ovf_f, res_f});
  assign out_null = ~|{ovf_t, res_t, ovf_f, res_f};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: compare on every null-to-data transition of the outputs
  bit prev_d = 1'b0;
  always @(negedge clk) begin
    if (rst) prev_d = 1'b0;
    else begin
      if (!out_null && !out_data)
        chk(1'b0, "R2", "mixed null/data output", {ovf_t, res_t}, {ovf_f, res_f});
      if (out_data && !prev_d) begin
        if (sb_q.size() == 0) chk(1'b0, "R2", "unexpected result", {ovf_t, res_t}, '0);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(res_t == e.res && res_f == ~e.res, e.req, "result", {1'b0, res_t}, {1'b0, e.res});
          chk(ovf_t == e.ovf && ovf_f == !e.ovf, "R9", "carry-out", {{W{1'b0}}, ovf_t}, {{W{1'b0}}, e.ovf});
        end
      end
      prev_d = out_data;
    end
  end

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic sub, input logic lop, input logic rsel, input string req);
    exp_t e;
    logic [W-1:0] bb, msk;
    logic [W:0] full;
    bb       = sub ? ~b : b;
    full     = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, sub};
    e.res    = rsel ? (lop ? (a | b) : (a & b)) : full[W-1:0];
    e.ovf    = full[W];
    e.req    = req;
    sb_q.push_back(e);
    msk      = {1'b1, {(W-1){1'b0}}};
    @(negedge clk);
    opb_t = b; opb_f = ~b;
    sub_t = sub; sub_f = !sub; lop_t = lop; lop_f = !lop; rsel_t = rsel; rsel_f = !rsel;
    opa_t = a & ~msk; opa_f = ~a & ~msk;        // top bit of A still null
    repeat (SKEW) @(negedge clk);
    chk(out_null, "R3", "outputs left null with one input bit null", {ovf_t, res_t}, '0);
    opa_t = a; opa_f = ~a;
    for (int k = 0; k < WAIT; k++) begin
      @(negedge clk);
      if (out_data) break;
    end
    chk(out_data, "R2", "data wave completes", {ovf_t, res_t}, {e.ovf, e.res});
    opa_t = '0; opa_f = '0;                      // half-null wave
    repeat (SKEW) @(negedge clk);
    chk(out_data && res_t == e.res && ovf_t == e.ovf, "R4", "data held while inputs partly null",
        {ovf_t, res_t}, {e.ovf, e.res});
    opb_t = '0; opb_f = '0; sub_t = 0; sub_f = 0; lop_t = 0; lop_f = 0; rsel_t = 0; rsel_f = 0;
    for (int k = 0; k < WAIT; k++) begin
      @(negedge clk);
      if (out_null) break;
    end
    chk(out_null, "R4", "return to null", {ovf_t, res_t}, '0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_null, "R11", "outputs null after reset", {ovf_t, res_t}, '0);
    chk(!rail_err, "R11", "error clear after reset", {{W{1'b0}}, rail_err}, '0);

    run_op(32'd2, 32'd1, 1'b0, 1'b0, 1'b0, "R5");
    run_op(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b0, "R5");
    run_op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b0, "R5");
    run_op(32'd2, 32'd1, 1'b1, 1'b0, 1'b0, "R6");
    run_op(32'd1, 32'd2, 1'b1, 1'b0, 1'b0, "R6");
    run_op(32'd0, 32'd0, 1'b1, 1'b1, 1'b0, "R6");
    run_op(32'h8000_0000, 32'h0000_0001, 1'b1, 1'b0, 1'b0, "R6");
    run_op(32'hF0F0_1234, 32'hFF00_5678, 1'b0, 1'b0, 1'b1, "R7");
    run_op(32'hFFFF_FFFF, 32'hA5A5_5A5A, 1'b1, 1'b0, 1'b1, "R7");
    run_op(32'hF0F0_1234, 32'h0F00_5678, 1'b0, 1'b1, 1'b1, "R8");
    run_op(32'h0000_0000, 32'h8000_0001, 1'b1, 1'b1, 1'b1, "R8");
    for (int n = 0; n < 4; n++)
      run_op($urandom, $urandom, n[0], n[1], 1'b0, n[0] ? "R6" : "R5");

    // R10: illegal pair sets a sticky flag; R11: reset clears it
    @(negedge clk);
    opa_t[3] = 1'b1; opa_f[3] = 1'b1;
    repeat (2) @(negedge clk);
    chk(rail_err, "R10", "flag after 11 pair", {{W{1'b0}}, rail_err}, 1);
    opa_t = '0; opa_f = '0;
    repeat (5) @(negedge clk);
    chk(rail_err, "R10", "flag sticky after pair cleared", {{W{1'b0}}, rail_err}, 1);
    chk(out_null, "R1", "outputs stay null after illegal input", {ovf_t, res_t}, '0);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!rail_err && out_null, "R11", "reset clears flag", {{W{1'b0}}, rail_err}, '0);
    chk(sb_q.size() == 0, "R2", "all expected results seen", W'(sb_q.size()), '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule